// File: doc/BRIEF.md
# Indexed-Color Scanout Engine with Dirty-Row Skipping

The engine walks an 8-bit-per-pixel frame buffer one row at a time and turns each pixel byte into a 32-bit word. It does this by looking the byte up in an external palette that returns 24 bits of colour. The finished words go out on a pixel write port. The engine keeps one dirty bit per row, and a sticky full-redraw flag. A row is converted only when its dirty bit or the full-redraw flag is set. Any other row is passed over without touching memory.

Converted rows that sit next to each other are merged into one update rectangle. Each rectangle spans the full width and is reported as a start row plus a row count. The report goes out as soon as a skipped row breaks the run, or when the frame ends. A one-cycle frame-done pulse marks the end of each frame, and a vertical-sync interrupt source can use it directly. Frame width and height are inputs from 0 to 2048. A frame begins only on a start strobe while the engine is idle.

The controller is a five-state machine:
- **ST_IDLE** waits for `start`. On `start` it latches the dimensions and goes to ST_CHECK.
- **ST_CHECK** examines row `y`:
  - past the last row, it goes to ST_CLOSE;
  - on a row that needs converting, it goes to ST_RUN;
  - on a row that is skipped, it stays in ST_CHECK and moves to the next row.
- **ST_RUN** issues one VRAM read per cycle. After the last column it goes to ST_DRAIN.
- **ST_DRAIN** waits until the two-stage read/lookup pipeline is empty, then returns to ST_CHECK on the next row.
- **ST_CLOSE** flushes any open rectangle, clears the full-redraw flag and returns to ST_IDLE.

Top module: `idx_scanout`

## Requirements
- R1: After reset, `busy`, `vram_re`, `pal_re`, `pix_we`, `rect_valid` and `frame_done` are all 0. The full-redraw flag is set and every dirty bit is clear, so the first frame converts every row.
- R2: A converted row `y` of a frame of width `W` reads VRAM addresses `y*W + x` for x = 0 to W-1, each exactly once and in ascending order. Each `pix_we` appears exactly three cycles after the `vram_re` that fetched that pixel.
- R3: Each `pix_data` is `{8'h00, pal_rgb}`, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. `pal_rgb` is the palette entry returned for the byte read at that pixel. `pix_addr` equals the VRAM address of that pixel. `pal_idx` carries the VRAM byte in the cycle after the read, with `pal_re` high.
- R4: A row is converted when its dirty bit or the full-redraw flag is set (and the width is nonzero). Otherwise it produces no VRAM read and no pixel write.
- R5: A maximal run of consecutive converted rows produces exactly one `rect_valid` pulse, carrying `rect_start` = first row and `rect_count` = number of rows. Runs are reported in ascending row order.
- R6: A rectangle is reported only after the last pixel of its run has been written. `frame_done` is a one-cycle pulse that comes after every pixel write and rectangle of the frame, in the first cycle `busy` is low.
- R7: A `pal_wr` pulse sets the full-redraw flag, so the next frame converts every row. The flag is cleared when a frame ends.
- R8: `mark_we` sets the dirty bit of `mark_row`, and that bit stays set until the row is examined by a frame. Examining a row clears its bit, whether or not the row was converted. A mark in the same cycle as the clear wins.
- R9: `invalidate` sets every dirty bit, so the next frame converts every row.
- R10: `start` has no effect while `busy` is high. No second frame follows.
- R11: A frame with width 0 or height 0 produces no VRAM read and no rectangle, and still ends with `frame_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a frame when the engine is idle |
| frame_w | input | 12 | Frame width in pixels, 0 to 2048 |
| frame_h | input | 12 | Frame height in rows, 0 to 2048 |
| mark_we | input | 1 | Marks one row dirty |
| mark_row | input | 11 | Row index to mark |
| invalidate | input | 1 | Marks every row dirty |
| pal_wr | input | 1 | Palette was changed; forces a full redraw |
| vram_re | output | 1 | VRAM read request |
| vram_addr | output | 22 | VRAM byte address |
| vram_rdata | input | 8 | VRAM byte, valid the cycle after `vram_re` |
| pal_re | output | 1 | Palette lookup request |
| pal_idx | output | 8 | Palette index |
| pal_rgb | input | 24 | Palette colour, valid the cycle after `pal_re` |
| pix_we | output | 1 | Pixel write strobe |
| pix_addr | output | 22 | Pixel position `y*W + x` |
| pix_data | output | 32 | Converted pixel word |
| rect_valid | output | 1 | Update rectangle report strobe |
| rect_start | output | 11 | First row of the rectangle |
| rect_count | output | 12 | Number of rows in the rectangle |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | High while a frame is in progress |

## Verification
A stale dirty bit or a wrong full-redraw flag shows up at the ports within a single frame, in one of three ways:
- a row that should be skipped is converted: the first unexpected `pix_we` is flagged on the cycle it appears;
- a row that should be converted is skipped: it reaches the frame-done pulse with expected pixels still outstanding;
- a run is not merged or is broken wrongly: either gives a rectangle whose start or count does not match.

A wrong row base or column counter corrupts `pix_addr` on the first pixel of the affected row. A pipeline valid bit that is out of step shifts the palette colour onto the wrong address three cycles after the read.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RUN,
        ST_DRAIN,
        ST_CLOSE
    } scan_state_e;

    localparam int PIX_PIPE_DEPTH = 3;
endpackage

// File: rtl/scan_dirty_map.sv
module scan_dirty_map #(
    parameter int MAX_ROWS = 2048,
    parameter int ROW_W    = $clog2(MAX_ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark_we,
    input  logic [ROW_W-1:0] mark_row,
    input  logic             invalidate,
    input  logic             clr_en,
    input  logic [ROW_W-1:0] clr_row,
    input  logic [ROW_W-1:0] rd_row,
    output logic             rd_dirty
);
    logic [MAX_ROWS-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (invalidate) begin
            bits_q <= '1;
        end else begin
            if (clr_en && (int'(clr_row) < MAX_ROWS))
                bits_q[clr_row] <= 1'b0;
            if (mark_we && (int'(mark_row) < MAX_ROWS))
                bits_q[mark_row] <= 1'b1;
        end
    end

    always_comb begin
        rd_dirty = 1'b0;
        if (int'(rd_row) < MAX_ROWS)
            rd_dirty = bits_q[rd_row];
    end

    // A mark must be visible at the next read of that row (R8)
    assert_mark_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_we && !invalidate) |=> bits_q[$past(mark_row)]);
endmodule

// File: rtl/scan_pix_pipe.sv
module scan_pix_pipe #(
    parameter int ADDR_W    = 22,
    parameter int PIX_BITS  = 8,
    parameter int RGB_BITS  = 24,
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [ADDR_W-1:0]    issue_addr,
    output logic                 vram_re,
    output logic [ADDR_W-1:0]    vram_addr,
    input  logic [PIX_BITS-1:0]  vram_rdata,
    output logic                 pal_re,
    output logic [PIX_BITS-1:0]  pal_idx,
    input  logic [RGB_BITS-1:0]  pal_rgb,
    output logic                 pix_we,
    output logic [ADDR_W-1:0]    pix_addr,
    output logic [WORD_BITS-1:0] pix_data,
    output logic                 pipe_busy
);
    localparam int PAD_W = WORD_BITS - RGB_BITS;

    logic              v1_q, v2_q;
    logic [ADDR_W-1:0] a1_q, a2_q;

    assign vram_re   = issue;
    assign vram_addr = issue_addr;
    assign pal_re    = v1_q;
    assign pal_idx   = vram_rdata;
    assign pipe_busy = v1_q | v2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q     <= 1'b0;
            v2_q     <= 1'b0;
            a1_q     <= '0;
            a2_q     <= '0;
            pix_we   <= 1'b0;
            pix_addr <= '0;
            pix_data <= '0;
        end else begin
            v1_q   <= issue;
            a1_q   <= issue_addr;
            v2_q   <= v1_q;
            a2_q   <= a1_q;
            pix_we <= v2_q;
            if (v2_q) begin
                pix_addr <= a2_q;
                pix_data <= {{PAD_W{1'b0}}, pal_rgb};
            end
        end
    end

    assert_pix_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> $past(vram_re, 3));
    assert_pal_follows_vram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pal_re |-> $past(vram_re));
endmodule

// File: rtl/scan_run_tracker.sv
module scan_run_tracker #(
    parameter int ROW_W = 11,
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [ROW_W-1:0] take_row,
    input  logic             close,
    output logic             rect_valid,
    output logic [ROW_W-1:0] rect_start,
    output logic [DIM_W-1:0] rect_count
);
    logic             active_q;
    logic [ROW_W-1:0] first_q;
    logic [DIM_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            first_q    <= '0;
            cnt_q      <= '0;
            rect_valid <= 1'b0;
            rect_start <= '0;
            rect_count <= '0;
        end else begin
            rect_valid <= 1'b0;
            if (take) begin
                if (!active_q) begin
                    active_q <= 1'b1;
                    first_q  <= take_row;
                    cnt_q    <= DIM_W'(1);
                end else begin
                    cnt_q <= cnt_q + DIM_W'(1);
                end
            end else if (close && active_q) begin
                active_q   <= 1'b0;
                rect_valid <= 1'b1;
                rect_start <= first_q;
                rect_count <= cnt_q;
            end
        end
    end

    // A run only grows by the row right after its current end (R5)
    assert_run_contiguous_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && active_q) |-> ((DIM_W'(take_row)) == (DIM_W'(first_q) + cnt_q)));
endmodule

// File: rtl/idx_scanout.sv
module idx_scanout
    import scan_pkg::*;
#(
    parameter int MAX_DIM   = 2048,
    parameter int PIX_BITS  = 8,
    parameter int RGB_BITS  = 24,
    parameter int WORD_BITS = 32,
    parameter int DIM_W     = $clog2(MAX_DIM + 1),
    parameter int ROW_W     = $clog2(MAX_DIM),
    parameter int ADDR_W    = $clog2(MAX_DIM * MAX_DIM)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DIM_W-1:0]     frame_w,
    input  logic [DIM_W-1:0]     frame_h,
    input  logic                 mark_we,
    input  logic [ROW_W-1:0]     mark_row,
    input  logic                 invalidate,
    input  logic                 pal_wr,
    output logic                 vram_re,
    output logic [ADDR_W-1:0]    vram_addr,
    input  logic [PIX_BITS-1:0]  vram_rdata,
    output logic                 pal_re,
    output logic [PIX_BITS-1:0]  pal_idx,
    input  logic [RGB_BITS-1:0]  pal_rgb,
    output logic                 pix_we,
    output logic [ADDR_W-1:0]    pix_addr,
    output logic [WORD_BITS-1:0] pix_data,
    output logic                 rect_valid,
    output logic [ROW_W-1:0]     rect_start,
    output logic [DIM_W-1:0]     rect_count,
    output logic                 frame_done,
    output logic                 busy
);
    scan_state_e state_q, state_d;

    logic [DIM_W-1:0]  w_q, h_q, y_q, x_q;
    logic [ADDR_W-1:0] base_q;
    logic              full_q;
    logic              row_dirty, in_range, convert, pipe_busy;
    logic              issue, clr_en, take, close;
    logic [ADDR_W-1:0] issue_addr;

    assign in_range = (y_q < h_q);
    assign convert  = (row_dirty | full_q) && (w_q != '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!in_range)    state_d = ST_CLOSE;
                else if (convert) state_d = ST_RUN;
            end
            ST_RUN:   if (x_q == (w_q - DIM_W'(1))) state_d = ST_DRAIN;
            ST_DRAIN: if (!pipe_busy) state_d = ST_CHECK;
            ST_CLOSE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Counters and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q        <= '0;
            h_q        <= '0;
            y_q        <= '0;
            x_q        <= '0;
            base_q     <= '0;
            full_q     <= 1'b1;
            frame_done <= 1'b0;
        end else begin
            frame_done <= (state_q == ST_CLOSE);
            if (pal_wr)                  full_q <= 1'b1;
            else if (state_q == ST_CLOSE) full_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    w_q    <= frame_w;
                    h_q    <= frame_h;
                    y_q    <= '0;
                    x_q    <= '0;
                    base_q <= '0;
                end
                ST_CHECK: if (in_range) begin
                    if (convert) begin
                        x_q <= '0;
                    end else begin
                        y_q    <= y_q + DIM_W'(1);
                        base_q <= base_q + ADDR_W'(w_q);
                    end
                end
                ST_RUN:   x_q <= x_q + DIM_W'(1);
                ST_DRAIN: if (!pipe_busy) begin
                    y_q    <= y_q + DIM_W'(1);
                    base_q <= base_q + ADDR_W'(w_q);
                end
                ST_CLOSE: ;
                default: ;
            endcase
        end
    end

    // Outputs of the controller
    always_comb begin
        issue      = (state_q == ST_RUN);
        issue_addr = base_q + ADDR_W'(x_q);
        clr_en     = (state_q == ST_CHECK) && in_range;
        take       = clr_en && convert;
        close      = (clr_en && !convert) || (state_q == ST_CLOSE);
        busy       = (state_q != ST_IDLE);
    end

    scan_dirty_map #(.MAX_ROWS(MAX_DIM), .ROW_W(ROW_W)) u_dirty (
        .clk(clk), .rst_n(rst_n),
        .mark_we(mark_we), .mark_row(mark_row), .invalidate(invalidate),
        .clr_en(clr_en), .clr_row(y_q[ROW_W-1:0]),
        .rd_row(y_q[ROW_W-1:0]), .rd_dirty(row_dirty)
    );

    scan_pix_pipe #(.ADDR_W(ADDR_W), .PIX_BITS(PIX_BITS), .RGB_BITS(RGB_BITS),
                    .WORD_BITS(WORD_BITS)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .issue(issue), .issue_addr(issue_addr),
        .vram_re(vram_re), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
        .pal_re(pal_re), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
        .pix_we(pix_we), .pix_addr(pix_addr), .pix_data(pix_data),
        .pipe_busy(pipe_busy)
    );

    scan_run_tracker #(.ROW_W(ROW_W), .DIM_W(DIM_W)) u_runs (
        .clk(clk), .rst_n(rst_n),
        .take(take), .take_row(y_q[ROW_W-1:0]), .close(close),
        .rect_valid(rect_valid), .rect_start(rect_start), .rect_count(rect_count)
    );

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !vram_re);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    assert_rect_after_pixels_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> !pix_we);
    assert_rect_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> ((DIM_W+1)'(rect_start) + (DIM_W+1)'(rect_count) <= (DIM_W+1)'(h_q)));
endmodule

// File: tb/idx_scanout_test.sv
module idx_scanout_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] frame_w = '0, frame_h = '0;
    logic        mark_we = 1'b0;
    logic [10:0] mark_row = '0;
    logic        invalidate = 1'b0, pal_wr = 1'b0;
    logic        vram_re, pal_re, pix_we, rect_valid, frame_done, busy;
    logic [21:0] vram_addr, pix_addr;
    logic [7:0]  vram_rdata = '0, pal_idx;
    logic [23:0] pal_rgb = '0;
    logic [31:0] pix_data;
    logic [10:0] rect_start;
    logic [11:0] rect_count;

    always #4 clk = ~clk;

    idx_scanout uut (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_w(frame_w), .frame_h(frame_h),
        .mark_we(mark_we), .mark_row(mark_row), .invalidate(invalidate), .pal_wr(pal_wr),
        .vram_re(vram_re), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
        .pal_re(pal_re), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
        .pix_we(pix_we), .pix_addr(pix_addr), .pix_data(pix_data),
        .rect_valid(rect_valid), .rect_start(rect_start), .rect_count(rect_count),
        .frame_done(frame_done), .busy(busy)
    );

    logic [7:0]  vmem [0:4095];
    logic [23:0] pmem [0:255];
    always @(posedge clk) begin
        vram_rdata <= vmem[vram_addr[11:0]];
        pal_rgb    <= pmem[pal_idx];
    end

    int total = 0, bad = 0, done_cnt = 0, started = 0, cycles = 0;
    bit mdirty [0:2047];
    bit mfull = 1'b1;
    logic [53:0] expix [$];
    int exrs [$];
    int exrc [$];
    logic [53:0] e;
    int er, ec;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference comparison on every clock
    always @(negedge clk) if (rst_n) begin
        if (pix_we) begin
            if (expix.size() == 0) check(1'b0, "R4", "unexpected pixel write", pix_addr, 0);
            else begin
                e = expix.pop_front();
                check(pix_addr == e[53:32], "R2", "pixel address", pix_addr, e[53:32]);
                check(pix_data == e[31:0], "R3", "pixel word", pix_data, e[31:0]);
            end
        end
        if (rect_valid) begin
            if (exrs.size() == 0) check(1'b0, "R5", "unexpected rectangle", rect_start, 0);
            else begin
                er = exrs.pop_front();
                ec = exrc.pop_front();
                check(int'(rect_start) == er, "R5", "rect start", rect_start, er);
                check(int'(rect_count) == ec, "R5", "rect count", rect_count, ec);
            end
        end
        if (frame_done) begin
            check(expix.size() == 0, "R6", "pixels left at frame end", expix.size(), 0);
            check(exrs.size() == 0, "R6", "rects left at frame end", exrs.size(), 0);
            check(busy == 1'b0, "R6", "busy at frame_done", busy, 0);
            done_cnt++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "R6", "watchdog expired", cycles, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic mark(int row);
        @(negedge clk); mark_we = 1'b1; mark_row = 11'(row);
        @(negedge clk); mark_we = 1'b0;
        mdirty[row] = 1'b1;
    endtask

    task automatic do_invalidate();
        @(negedge clk); invalidate = 1'b1;
        @(negedge clk); invalidate = 1'b0;
        for (int i = 0; i < 2048; i++) mdirty[i] = 1'b1;
    endtask

    task automatic pal_change(int idx, logic [23:0] rgb);
        pmem[idx] = rgb;
        @(negedge clk); pal_wr = 1'b1;
        @(negedge clk); pal_wr = 1'b0;
        mfull = 1'b1;
    endtask

    task automatic run_frame(int w, int h, bit poke);
        int rs = -1;
        int target = done_cnt + 1;
        for (int y = 0; y < h; y++) begin
            bit conv = (mdirty[y] || mfull) && (w != 0);
            mdirty[y] = 1'b0;
            if (conv) begin
                if (rs < 0) rs = y;
                for (int x = 0; x < w; x++) begin
                    int a = y * w + x;
                    expix.push_back({22'(a), 8'h00, pmem[vmem[a]]});
                end
            end else if (rs >= 0) begin
                exrs.push_back(rs); exrc.push_back(y - rs); rs = -1;
            end
        end
        if (rs >= 0) begin exrs.push_back(rs); exrc.push_back(h - rs); end
        mfull = 1'b0;
        @(negedge clk); frame_w = 12'(w); frame_h = 12'(h); start = 1'b1;
        @(negedge clk); start = 1'b0;
        started++;
        if (poke) begin
            @(negedge clk);
            check(busy == 1'b1, "R10", "busy during frame", busy, 1);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (done_cnt < target) @(negedge clk);
        repeat (12) @(negedge clk);
        check(done_cnt == started, "R10", "frame count", done_cnt, started);
        check(busy == 1'b0, "R10", "idle after frame", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) vmem[i] = 8'((i * 37 + 11) & 255);
        for (int i = 0; i < 256; i++) pmem[i] = {8'(i ^ 8'h5a), 8'(i + 3), 8'(~i)};
        for (int i = 0; i < 2048; i++) mdirty[i] = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 0 && vram_re == 0 && pal_re == 0, "R1", "reset outputs a", {busy, vram_re, pal_re}, 0);
        check(pix_we == 0 && rect_valid == 0 && frame_done == 0, "R1", "reset outputs b",
              {pix_we, rect_valid, frame_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_frame(16, 8, 1'b0);         // R1: full redraw after reset
        run_frame(16, 8, 1'b0);         // R8: dirty cleared, nothing converted
        mark(1); mark(2); mark(5);      // R5: runs (1,2) and (5,1)
        run_frame(16, 8, 1'b0);
        mark(0); mark(7);               // R5: run closed at frame end
        run_frame(16, 8, 1'b0);
        mark(3); mark(4);               // R10: start while busy is ignored
        run_frame(5, 6, 1'b1);
        pal_change(8'h42, 24'h123456);  // R7: palette change redraws all
        run_frame(16, 8, 1'b0);
        run_frame(16, 8, 1'b0);         // R7: flag cleared after frame
        do_invalidate();                // R9: all rows dirty
        run_frame(9, 7, 1'b0);
        mark(2);                        // R11: zero width, row examined
        run_frame(0, 4, 1'b0);
        run_frame(12, 0, 1'b0);         // R11: zero height
        mark(0); mark(2);               // R4/R8: width 1 single rows
        run_frame(1, 3, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule